// File: doc/BRIEF.md
# Three-Source Core Memory Access Arbiter

This block decides which of three independent requesters may start the next cycle on a shared, banked core memory. The requesters are a fast streaming device, a slower streaming device and the CPU. The streaming devices cannot be held off for long, so they always win over the CPU. The fast device also wins over the slow one. Device requests hold off new CPU orders. A CPU order that has already been taken into the buffer address register is not lost when a device arrives. It is lifted out into a save slot with its line address, page digits, target stacks and cycle type. It is then replayed as soon as every device request has been issued.

A CPU order is taken into the buffer address register in the cycle it is accepted. Its stack request goes out in a later cycle. Successive stack requests from any source are kept at least `GAP` cycles apart, which leaves room for parity checking of each read. When a saved operand order is replayed, the page digits held for instruction-pair fetches can no longer be trusted. The next pair fetch is therefore flagged for full translation. Address translation, array timing and parity are outside the block. The CPU side presents its translation result as a hit bit, its page digits and a stack mask.

Top module: `core_access_arbiter`

## Requirements
- R1: After reset, all grants, `mem_req`, `cpu_acc`, `cpu_miss` and `bar_busy` are low, and no stack request is made until some requester asks.
- R2: A CPU order presented while the buffer is free, no order is saved and no device is requesting is accepted in that cycle (`cpu_acc`). When the spacing allows, its stack request goes out in the next cycle, with `cpu_gnt`, `mem_src` = 3 and the order's line, page, stack mask and write bit.
- R3: Fixed priority is fast device, then slow device, then CPU (saved order first, then buffered order). A device cycle drives `mem_src` = 1 (fast) or 2 (slow), a one-hot `mem_stk` with bit `idx` set, the device's line, and page digits zero.
- R4: At most one of the three grants is high in any cycle, and `mem_req` is high exactly when one of them is.
- R5: `cpu_acc` stays low while any device request is present, while the buffer is busy, and while a saved CPU order exists.
- R6: If a device request is present while the buffer holds a hit order, `bar_busy` is low in the next cycle. The order is later issued with its original line, page, stacks and write bit.
- R7: A saved order is replayed only in a slot with no device request. A device request that arrives before the replay is served first.
- R8: The first CPU instruction-pair issue after a replayed operand (non-pair) order has `mem_full_xlate` high. Every other CPU issue has it low.
- R9: Two stack requests are never closer than `GAP` cycles.
- R10: An accepted order whose hit bit is low makes no stack request. `cpu_miss` pulses in the cycle after acceptance, with `bar_busy` high, and the buffer is free one cycle later.
- R11: A fast device request waits fewer than `GAP` cycles before its grant.
- R12: `cpu_acc` can be high again in the cycle right after the replayed order's stack request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU order present |
| cpu_hit | input | 1 | Translation hit for the CPU order |
| cpu_pair | input | 1 | Order is an instruction-pair fetch |
| cpu_write | input | 1 | Order writes memory |
| cpu_line | input | LINE_W | Line address inside the page |
| cpu_page | input | PAGE_W | Page digits from translation |
| cpu_stk | input | NSTK | Target stack mask |
| cpu_acc | output | 1 | Order taken into the buffer this cycle |
| cpu_gnt | output | 1 | CPU stack request issued this cycle |
| cpu_miss | output | 1 | Buffered order released without access |
| fdev_req | input | 1 | Fast device request, held until granted |
| fdev_write | input | 1 | Fast device write cycle |
| fdev_idx | input | $clog2(NSTK) | Fast device stack index |
| fdev_line | input | LINE_W | Fast device line address |
| fdev_gnt | output | 1 | Fast device stack request issued |
| sdev_req | input | 1 | Slow device request, held until granted |
| sdev_write | input | 1 | Slow device write cycle |
| sdev_idx | input | $clog2(NSTK) | Slow device stack index |
| sdev_line | input | LINE_W | Slow device line address |
| sdev_gnt | output | 1 | Slow device stack request issued |
| bar_busy | output | 1 | Buffer address register holds an order |
| mem_req | output | 1 | Stack request this cycle |
| mem_stk | output | NSTK | Stack select mask |
| mem_line | output | LINE_W | Line address of the issued cycle |
| mem_page | output | PAGE_W | Page digits of the issued cycle |
| mem_write | output | 1 | Issued cycle writes |
| mem_src | output | 2 | Source code: 1 fast, 2 slow, 3 CPU |
| mem_full_xlate | output | 1 | Pair fetch must use full translation |

## Verification
The bench builds the arbiter with `GAP` = 2, four stacks, 9-bit lines and 5-bit page digits. With a gap of 2, a device grant always leaves a dead cycle. In that cycle a second device request can arrive ahead of a saved CPU order, which makes the replay-reordering case easy to reach. Two stacks per pair mask exercise multi-bit stack selects. A fast device arriving no more often than every four cycles keeps the slow device and CPU slots in play during the random run.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FAST = 2'd1,
        SRC_SLOW = 2'd2,
        SRC_CPU  = 2'd3
    } src_e;

endpackage

// File: rtl/arb_gap_timer.sv
module arb_gap_timer #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic ready
);
    localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } gap_state_t;

    gap_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (fire) begin
            nxt_d.cnt = CW'(GAP - 1);
        end else if (cur_q.cnt != '0) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ready = (cur_q.cnt == '0);

    // R9: a request is only ever launched into a free slot
    a_r9_fire_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ready);

endmodule

// File: rtl/arb_stack_onehot.sv
module arb_stack_onehot #(
    parameter int NSTK = 4,
    parameter int IW   = 2
) (
    input  logic [IW-1:0]   idx,
    output logic [NSTK-1:0] mask
);
    for (genvar i = 0; i < NSTK; i++) begin : g_bit
        assign mask[i] = (idx == IW'(i));
    end
endmodule

// File: rtl/core_access_arbiter.sv
module core_access_arbiter
    import arb_pkg::*;
#(
    parameter int NSTK   = 4,
    parameter int LINE_W = 9,
    parameter int PAGE_W = 5,
    parameter int GAP    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req,
    input  logic                      cpu_hit,
    input  logic                      cpu_pair,
    input  logic                      cpu_write,
    input  logic [LINE_W-1:0]         cpu_line,
    input  logic [PAGE_W-1:0]         cpu_page,
    input  logic [NSTK-1:0]           cpu_stk,
    output logic                      cpu_acc,
    output logic                      cpu_gnt,
    output logic                      cpu_miss,
    input  logic                      fdev_req,
    input  logic                      fdev_write,
    input  logic [$clog2(NSTK)-1:0]   fdev_idx,
    input  logic [LINE_W-1:0]         fdev_line,
    output logic                      fdev_gnt,
    input  logic                      sdev_req,
    input  logic                      sdev_write,
    input  logic [$clog2(NSTK)-1:0]   sdev_idx,
    input  logic [LINE_W-1:0]         sdev_line,
    output logic                      sdev_gnt,
    output logic                      bar_busy,
    output logic                      mem_req,
    output logic [NSTK-1:0]           mem_stk,
    output logic [LINE_W-1:0]         mem_line,
    output logic [PAGE_W-1:0]         mem_page,
    output logic                      mem_write,
    output logic [1:0]                mem_src,
    output logic                      mem_full_xlate
);
    localparam int IW  = $clog2(NSTK);
    localparam int SCW = $clog2(GAP + 1) + 1;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              pair;
        logic              write;
        logic [LINE_W-1:0] line;
        logic [PAGE_W-1:0] page;
        logic [NSTK-1:0]   stk;
    } order_t;

    typedef struct packed {
        order_t bar;
        order_t park;
        logic   force_full;
    } arb_state_t;

    arb_state_t cur_q, nxt_d;

    logic            slot_ok;
    logic            dev_pend;
    logic [NSTK-1:0] fmask, smask;

    arb_stack_onehot #(.NSTK(NSTK), .IW(IW)) u_fdec (.idx(fdev_idx), .mask(fmask));
    arb_stack_onehot #(.NSTK(NSTK), .IW(IW)) u_sdec (.idx(sdev_idx), .mask(smask));

    arb_gap_timer #(.GAP(GAP)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (mem_req),
        .ready (slot_ok)
    );

    always_comb begin
        nxt_d          = cur_q;
        fdev_gnt       = 1'b0;
        sdev_gnt       = 1'b0;
        cpu_gnt        = 1'b0;
        mem_req        = 1'b0;
        mem_stk        = '0;
        mem_line       = '0;
        mem_page       = '0;
        mem_write      = 1'b0;
        mem_src        = SRC_NONE;
        mem_full_xlate = 1'b0;

        dev_pend = fdev_req | sdev_req;
        cpu_miss = cur_q.bar.valid & ~cur_q.bar.hit;
        cpu_acc  = cpu_req & ~cur_q.bar.valid & ~cur_q.park.valid & ~dev_pend;

        // issue selection: fast, slow, saved CPU order, buffered CPU order
        if (slot_ok) begin
            if (fdev_req) begin
                fdev_gnt  = 1'b1;
                mem_req   = 1'b1;
                mem_stk   = fmask;
                mem_line  = fdev_line;
                mem_write = fdev_write;
                mem_src   = SRC_FAST;
            end else if (sdev_req) begin
                sdev_gnt  = 1'b1;
                mem_req   = 1'b1;
                mem_stk   = smask;
                mem_line  = sdev_line;
                mem_write = sdev_write;
                mem_src   = SRC_SLOW;
            end else if (cur_q.park.valid) begin
                cpu_gnt   = 1'b1;
                mem_req   = 1'b1;
                mem_stk   = cur_q.park.stk;
                mem_line  = cur_q.park.line;
                mem_page  = cur_q.park.page;
                mem_write = cur_q.park.write;
                mem_src   = SRC_CPU;
                nxt_d.park.valid = 1'b0;
                if (cur_q.park.pair) begin
                    mem_full_xlate   = cur_q.force_full;
                    nxt_d.force_full = 1'b0;
                end else begin
                    nxt_d.force_full = 1'b1;
                end
            end else if (cur_q.bar.valid && cur_q.bar.hit) begin
                cpu_gnt   = 1'b1;
                mem_req   = 1'b1;
                mem_stk   = cur_q.bar.stk;
                mem_line  = cur_q.bar.line;
                mem_page  = cur_q.bar.page;
                mem_write = cur_q.bar.write;
                mem_src   = SRC_CPU;
                nxt_d.bar.valid = 1'b0;
                if (cur_q.bar.pair) begin
                    mem_full_xlate   = cur_q.force_full;
                    nxt_d.force_full = 1'b0;
                end
            end
        end

        // buffer housekeeping: release misses, lift hit orders out for devices
        if (cur_q.bar.valid && !cur_q.bar.hit) begin
            nxt_d.bar.valid = 1'b0;
        end else if (cur_q.bar.valid && dev_pend) begin
            nxt_d.park      = cur_q.bar;
            nxt_d.bar.valid = 1'b0;
        end

        if (cpu_acc) begin
            nxt_d.bar.valid = 1'b1;
            nxt_d.bar.hit   = cpu_hit;
            nxt_d.bar.pair  = cpu_pair;
            nxt_d.bar.write = cpu_write;
            nxt_d.bar.line  = cpu_line;
            nxt_d.bar.page  = cpu_page;
            nxt_d.bar.stk   = cpu_stk;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign bar_busy = cur_q.bar.valid;

    // ---------------- checking state and assertions ----------------
    logic [SCW-1:0] since_q;
    logic [SCW-1:0] fwait_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= SCW'(GAP);
            fwait_q <= '0;
        end else begin
            if (mem_req)                 since_q <= '0;
            else if (since_q < SCW'(GAP)) since_q <= since_q + 1'b1;
            if (fdev_req && !fdev_gnt)   fwait_q <= fwait_q + 1'b1;
            else                         fwait_q <= '0;
        end
    end

    a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fdev_gnt, sdev_gnt, cpu_gnt}));

    a_r3_fast_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fdev_req && mem_req) |-> fdev_gnt);

    a_r3_cpu_yields: assert property (@(posedge clk) disable iff (!rst_n)
        (fdev_req || sdev_req) |-> !cpu_gnt);

    a_r5_no_accept_dev: assert property (@(posedge clk) disable iff (!rst_n)
        (fdev_req || sdev_req || bar_busy) |-> !cpu_acc);

    a_r6_park_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_busy && (fdev_req || sdev_req)) |=> !bar_busy);

    a_r9_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (since_q >= SCW'(GAP - 1)));

    a_r10_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_miss |-> (!cpu_gnt && bar_busy));

    a_r10_miss_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_miss |=> !cpu_miss);

    a_r11_fast_wait: assert property (@(posedge clk) disable iff (!rst_n)
        fdev_req |-> (fwait_q < SCW'(GAP)));

    a_r8_xlate_pair_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_full_xlate |-> cpu_gnt);

endmodule

// File: tb/sim_core_access_arbiter.sv
`timescale 1ns/1ps
module sim_core_access_arbiter;
    localparam int NS  = 4;
    localparam int LW  = 9;
    localparam int PW  = 5;
    localparam int GAP = 2;
    localparam int IW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          cpu_req, cpu_hit, cpu_pair, cpu_write;
    logic [LW-1:0] cpu_line;
    logic [PW-1:0] cpu_page;
    logic [NS-1:0] cpu_stk;
    logic          fdev_req, fdev_write, sdev_req, sdev_write;
    logic [IW-1:0] fdev_idx, sdev_idx;
    logic [LW-1:0] fdev_line, sdev_line;
    logic          cpu_acc, cpu_gnt, cpu_miss, fdev_gnt, sdev_gnt, bar_busy;
    logic          mem_req, mem_write, mem_full_xlate;
    logic [NS-1:0] mem_stk;
    logic [LW-1:0] mem_line;
    logic [PW-1:0] mem_page;
    logic [1:0]    mem_src;

    // bench-side drive copies, applied at the falling edge
    logic          d_cpu_req = 0, d_cpu_hit = 0, d_cpu_pair = 0, d_cpu_write = 0;
    logic [LW-1:0] d_cpu_line = '0;
    logic [PW-1:0] d_cpu_page = '0;
    logic [NS-1:0] d_cpu_stk = '0;
    logic          d_fdev_req = 0, d_fdev_write = 0, d_sdev_req = 0, d_sdev_write = 0;
    logic [IW-1:0] d_fdev_idx = '0, d_sdev_idx = '0;
    logic [LW-1:0] d_fdev_line = '0, d_sdev_line = '0;

    core_access_arbiter #(.NSTK(NS), .LINE_W(LW), .PAGE_W(PW), .GAP(GAP)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_hit(cpu_hit), .cpu_pair(cpu_pair), .cpu_write(cpu_write),
        .cpu_line(cpu_line), .cpu_page(cpu_page), .cpu_stk(cpu_stk),
        .cpu_acc(cpu_acc), .cpu_gnt(cpu_gnt), .cpu_miss(cpu_miss),
        .fdev_req(fdev_req), .fdev_write(fdev_write), .fdev_idx(fdev_idx), .fdev_line(fdev_line),
        .fdev_gnt(fdev_gnt),
        .sdev_req(sdev_req), .sdev_write(sdev_write), .sdev_idx(sdev_idx), .sdev_line(sdev_line),
        .sdev_gnt(sdev_gnt),
        .bar_busy(bar_busy), .mem_req(mem_req), .mem_stk(mem_stk), .mem_line(mem_line),
        .mem_page(mem_page), .mem_write(mem_write), .mem_src(mem_src),
        .mem_full_xlate(mem_full_xlate)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int            win = 0;
    int            m_last = -100;
    int            m_fwait = 0;
    bit            m_out = 0, m_parked = 0, m_force = 0, m_miss_due = 0;
    bit            m_pair = 0, m_write = 0;
    logic [LW-1:0] m_line = '0;
    logic [PW-1:0] m_page = '0;
    logic [NS-1:0] m_stk = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] onehot(input logic [IW-1:0] i);
        return NS'(1) << i;
    endfunction

    task automatic model_check();
        bit free, e_fg, e_sg, e_cg, e_acc, e_busy;
        win++;
        free  = (win - m_last) >= GAP;
        e_fg  = fdev_req && free;
        e_sg  = !fdev_req && sdev_req && free;
        e_cg  = !fdev_req && !sdev_req && m_out && free;
        e_acc = cpu_req && !m_out && !m_miss_due && !fdev_req && !sdev_req;
        e_busy = m_miss_due || (m_out && !m_parked);

        chk(fdev_gnt == e_fg, "R3", "fast grant", fdev_gnt, e_fg);
        chk(sdev_gnt == e_sg, "R3", "slow grant", sdev_gnt, e_sg);
        chk(cpu_gnt == e_cg, m_parked ? "R7" : "R2", "cpu grant", cpu_gnt, e_cg);
        chk(cpu_acc == e_acc, (fdev_req || sdev_req) ? "R5" : "R2", "accept", cpu_acc, e_acc);
        chk(bar_busy == e_busy, "R6", "bar_busy", bar_busy, e_busy);
        chk(cpu_miss == m_miss_due, "R10", "miss pulse", cpu_miss, m_miss_due);
        chk(($countones({fdev_gnt, sdev_gnt, cpu_gnt}) <= 1) &&
            (mem_req == (fdev_gnt | sdev_gnt | cpu_gnt)), "R4", "one grant",
            mem_req, fdev_gnt | sdev_gnt | cpu_gnt);

        if (mem_req) begin
            chk((win - m_last) >= GAP, "R9", "spacing", win - m_last, GAP);
            m_last = win;
        end
        if (fdev_req && !fdev_gnt) m_fwait++;
        chk(m_fwait < GAP, "R11", "fast wait", m_fwait, GAP - 1);
        if (fdev_gnt) begin
            m_fwait = 0;
            chk(mem_line == fdev_line && mem_stk == onehot(fdev_idx) && mem_page == '0 &&
                mem_write == fdev_write && mem_src == 2'd1, "R3", "fast fields",
                int'(mem_line), int'(fdev_line));
        end
        if (sdev_gnt) begin
            chk(mem_line == sdev_line && mem_stk == onehot(sdev_idx) && mem_page == '0 &&
                mem_write == sdev_write && mem_src == 2'd2, "R3", "slow fields",
                int'(mem_line), int'(sdev_line));
        end
        if (mem_req && !cpu_gnt) chk(!mem_full_xlate, "R8", "xlate on device", mem_full_xlate, 0);
        if (cpu_gnt) begin
            chk(mem_line == m_line && mem_page == m_page && mem_stk == m_stk &&
                mem_write == m_write && mem_src == 2'd3, m_parked ? "R6" : "R2",
                "cpu fields", int'(mem_line), int'(m_line));
            chk(mem_full_xlate == (m_pair && m_force), "R8", "full xlate",
                mem_full_xlate, m_pair && m_force);
            if (m_pair)        m_force = 0;
            else if (m_parked) m_force = 1;
            m_out = 0;
            m_parked = 0;
        end
        if (m_out && (fdev_req || sdev_req)) m_parked = 1;
        m_miss_due = 0;
        if (e_acc) begin
            if (cpu_hit) begin
                m_out = 1; m_pair = cpu_pair; m_write = cpu_write;
                m_line = cpu_line; m_page = cpu_page; m_stk = cpu_stk;
            end else begin
                m_miss_due = 1;
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        cpu_req = d_cpu_req; cpu_hit = d_cpu_hit; cpu_pair = d_cpu_pair;
        cpu_write = d_cpu_write; cpu_line = d_cpu_line; cpu_page = d_cpu_page;
        cpu_stk = d_cpu_stk;
        fdev_req = d_fdev_req; fdev_write = d_fdev_write; fdev_idx = d_fdev_idx;
        fdev_line = d_fdev_line;
        sdev_req = d_sdev_req; sdev_write = d_sdev_write; sdev_idx = d_sdev_idx;
        sdev_line = d_sdev_line;
        #1;
        model_check();
    endtask

    task automatic idle(input int n);
        d_cpu_req = 0; d_fdev_req = 0; d_sdev_req = 0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_cpu(input bit hit, input bit pair, input bit wr,
                           input int line, input int page, input int stk);
        d_cpu_req = 1; d_cpu_hit = hit; d_cpu_pair = pair; d_cpu_write = wr;
        d_cpu_line = LW'(line); d_cpu_page = PW'(page); d_cpu_stk = NS'(stk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        chk(0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed));
        cpu_req = 0; cpu_hit = 0; cpu_pair = 0; cpu_write = 0; cpu_line = '0;
        cpu_page = '0; cpu_stk = '0; fdev_req = 0; fdev_write = 0; fdev_idx = '0;
        fdev_line = '0; sdev_req = 0; sdev_write = 0; sdev_idx = '0; sdev_line = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: quiet after reset
        step();
        chk(!mem_req && !bar_busy && !cpu_acc && !cpu_miss, "R1", "reset quiet",
            {mem_req, bar_busy, cpu_acc, cpu_miss}, 0);
        idle(2);

        // R2: simple operand order
        set_cpu(1, 0, 1, 'h55, 3, 'b0010);
        step();
        chk(cpu_acc && !mem_req, "R2", "accept cycle", cpu_acc, 1);
        d_cpu_req = 0;
        step();
        chk(cpu_gnt && mem_line == 'h55 && mem_page == 3 && mem_stk == 4'b0010 && mem_write,
            "R2", "issue next cycle", int'(mem_line), 'h55);
        step();
        chk(!mem_req && !bar_busy, "R9", "gap cycle", mem_req, 0);
        idle(3);

        // R3: everyone at once
        d_fdev_req = 1; d_fdev_idx = 2; d_fdev_line = 'h0F0; d_fdev_write = 1;
        d_sdev_req = 1; d_sdev_idx = 1; d_sdev_line = 'h111; d_sdev_write = 0;
        set_cpu(1, 0, 0, 'h022, 4, 'b1000);
        step();
        chk(fdev_gnt && mem_stk == 4'b0100 && mem_src == 2'd1, "R3", "fast wins",
            int'(mem_src), 1);
        d_fdev_req = 0;
        step();
        chk(!mem_req && !cpu_acc, "R5", "held off by slow", cpu_acc, 0);
        step();
        chk(sdev_gnt && mem_line == 'h111, "R3", "slow next", int'(mem_line), 'h111);
        d_sdev_req = 0;
        step();
        chk(cpu_acc, "R2", "cpu accepted after devices", cpu_acc, 1);
        d_cpu_req = 0;
        step();
        chk(cpu_gnt && mem_line == 'h022, "R3", "cpu last", int'(mem_line), 'h022);
        idle(3);

        // R6, R12, R8: park around a fast device, then pair fetches
        set_cpu(1, 0, 0, 'h1A3, 7, 'b0011);
        step();
        chk(cpu_acc, "R2", "operand accepted", cpu_acc, 1);
        d_cpu_req = 0;
        d_fdev_req = 1; d_fdev_idx = 2; d_fdev_line = 'h0F0;
        step();
        chk(fdev_gnt && bar_busy && !cpu_gnt, "R6", "device preempts buffer", fdev_gnt, 1);
        d_fdev_req = 0;
        set_cpu(1, 1, 0, 'h010, 7, 'b0011);
        step();
        chk(!bar_busy && !cpu_acc, "R6", "buffer freed, cpu held", bar_busy, 0);
        step();
        chk(cpu_gnt && mem_line == 'h1A3 && mem_page == 7 && mem_stk == 4'b0011 && !cpu_acc,
            "R6", "replay fields", int'(mem_line), 'h1A3);
        step();
        chk(cpu_acc, "R12", "accept after replay", cpu_acc, 1);
        d_cpu_req = 0;
        step();
        chk(cpu_gnt && mem_full_xlate, "R8", "pair forced full", mem_full_xlate, 1);
        set_cpu(1, 1, 0, 'h012, 7, 'b0011);
        step();
        chk(cpu_acc, "R2", "second pair accepted", cpu_acc, 1);
        d_cpu_req = 0;
        step();
        chk(cpu_gnt && !mem_full_xlate, "R8", "later pair bypass", mem_full_xlate, 0);
        idle(3);

        // R7: second device arrives before replay
        set_cpu(1, 0, 1, 'h0AA, 2, 'b0100);
        step();
        d_cpu_req = 0;
        d_sdev_req = 1; d_sdev_idx = 1; d_sdev_line = 'h111;
        step();
        chk(sdev_gnt, "R7", "slow preempts", sdev_gnt, 1);
        d_sdev_req = 0;
        d_fdev_req = 1; d_fdev_idx = 3; d_fdev_line = 'h033;
        step();
        chk(!mem_req, "R9", "gap after slow", mem_req, 0);
        step();
        chk(fdev_gnt && !cpu_gnt, "R7", "new device before replay", fdev_gnt, 1);
        d_fdev_req = 0;
        step();
        chk(!mem_req, "R7", "gap before replay", mem_req, 0);
        step();
        chk(cpu_gnt && mem_line == 'h0AA, "R7", "replay after devices", int'(mem_line), 'h0AA);
        idle(3);

        // R10: miss
        set_cpu(0, 0, 0, 'h077, 1, 'b0001);
        step();
        chk(cpu_acc, "R10", "miss accepted", cpu_acc, 1);
        d_cpu_req = 0;
        step();
        chk(cpu_miss && bar_busy && !mem_req, "R10", "miss pulse", cpu_miss, 1);
        step();
        chk(!cpu_miss && !bar_busy && !mem_req, "R10", "miss freed", bar_busy, 0);
        idle(2);

        // random phase
        begin
            int f_last = -100;
            int s_last = -100;
            for (int n = 0; n < 4000; n++) begin
                if (!d_fdev_req && (win - f_last) >= 4 && ($urandom() % 4) == 0) begin
                    d_fdev_req = 1; d_fdev_idx = IW'($urandom());
                    d_fdev_line = LW'($urandom()); d_fdev_write = 1'($urandom());
                end
                if (!d_sdev_req && (win - s_last) >= 11 && ($urandom() % 5) == 0) begin
                    d_sdev_req = 1; d_sdev_idx = IW'($urandom());
                    d_sdev_line = LW'($urandom()); d_sdev_write = 1'($urandom());
                end
                if (!d_cpu_req && !m_out && !m_miss_due && ($urandom() % 3) == 0) begin
                    bit pr;
                    pr = 1'($urandom());
                    set_cpu(($urandom() % 8) != 0, pr, pr ? 1'b0 : 1'($urandom()),
                            int'($urandom() % 512), int'($urandom() % 32),
                            pr ? (3 << (2 * ($urandom() % 2))) : (1 << ($urandom() % 4)));
                end
                step();
                if (fdev_gnt) begin d_fdev_req = 0; f_last = win; end
                if (sdev_gnt) begin d_sdev_req = 0; s_last = win; end
                if (cpu_acc)  d_cpu_req = 0;
            end
        end
        idle(4);
        finish_run();
    end
endmodule